// File: doc/BRIEF.md
# Video Transmitter Control Register Block

This block is the host-facing control and status register set for a video transmitter core. A host processor reaches it over a simple memory-mapped bus. The bus has byte addresses that must be word aligned, single-cycle read and write strobes, and a 32-bit data path. Register index `n` sits at byte offset `4*n`.

The block holds the following state:
- a full-word general control packet;
- thirteen payload bytes of the auxiliary video information frame;
- a high data-rate mode flag;
- four single-bit controls: hot-plug acknowledge, transceiver reset, PLL reset and reconfiguration enable;
- the transceiver channel number that reconfiguration applies to.

It also presents five busy and event inputs as one read-only status word.

The block packs the payload bytes into a 112-bit frame output. It fills the lowest byte of that frame with a checksum that it computes itself. The checksum has no register address. The transceiver, the PLLs and the reconfiguration engines are outside this block; only their control pins and busy pins reach it.

Top module: `vtx_ctrl_regs`

## Requirements
- R1: A write or read is decoded only when `bus_addr[1:0]` is `00` and the index `bus_addr[ADDR_W-1:2]` is 0 to 21. Any other address is unmapped: writes change nothing and reads return zero.
- R2: Index 0 (offset 0x00) holds a 32-bit control packet word. A write stores all 32 bits, a read returns them, and the word drives `ctl_packet`.
- R3: Index n, for n from 1 to 13 (offsets 0x04 to 0x34), stores `bus_wdata[7:0]` and drives `info_frame[8n+7:8n]`. A read returns that byte in bits [7:0], with zero above it.
- R4: `info_frame[7:0]` is the two's complement of the 8-bit sum of 0x82, 0x02, 0x0D and the 13 payload bytes. It is correct at the first sampling point after the clock edge that stores a payload byte.
- R5: Bit 0 of index 14 (offset 0x38) drives `hi_rate_mode`. A read returns only that bit.
- R6: Index 15 (offset 0x3C) holds no state. Reads of it return zero.
- R7: Index 16 (offset 0x40) is read-only. Bits [4:0] read as `iopll_cfg_busy`, `pll_cfg_busy`, `xcvr_cfg_busy`, `cal_busy`, `hotplug_evt` (bit 4 down to bit 0), and the upper bits read as zero. Writes to it are ignored.
- R8: Bit 0 of a write to index 17, 18, 19 or 20 (offsets 0x44, 0x48, 0x4C, 0x50) drives `hotplug_ack`, `xcvr_rst`, `pll_rst` or `reconf_en` respectively. A read returns that bit.
- R9: Index 21 (offset 0x54) stores `bus_wdata[CHAN_W-1:0]`, drives `reconf_chan`, and reads back zero-extended.
- R10: `bus_rdata` is registered. After a clock edge where `bus_rd` was high, it shows the register value as it was before any write in that same cycle. After an edge where `bus_rd` was low, it is zero.
- R11: With `rst_n` low at a clock edge, every register and `bus_rdata` clear to zero. `xcvr_rst` and `pll_rst` are therefore low, and `info_frame` equals 0x6F in its lowest byte with zero above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address from the host |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| hotplug_evt | input | 1 | Hot-plug event from the transmitter |
| cal_busy | input | 1 | Transceiver calibration busy |
| xcvr_cfg_busy | input | 1 | Transceiver reconfiguration busy |
| pll_cfg_busy | input | 1 | PLL reconfiguration busy |
| iopll_cfg_busy | input | 1 | IO-PLL reconfiguration busy |
| ctl_packet | output | DATA_W | General control packet word |
| info_frame | output | 112 | Packed frame: payload bytes above the checksum |
| hi_rate_mode | output | 1 | High data-rate transmit mode |
| hotplug_ack | output | 1 | Hot-plug acknowledge |
| xcvr_rst | output | 1 | Transceiver reset |
| pll_rst | output | 1 | PLL reset |
| reconf_en | output | 1 | Reconfiguration enable |
| reconf_chan | output | CHAN_W | Channel targeted by reconfiguration |

## Verification
A read and a write to the same register can fall in the same clock cycle. The bench provokes this by raising both strobes in one cycle on the control packet address with a new value. It expects `bus_rdata` to show the value stored before that cycle, and a following plain read to show the new value. The status word meets a similar overlap: the bench changes the busy inputs between reads and expects each read to show the inputs as they stood in the cycle of the read strobe.

// File: rtl/vtx_regs_pkg.sv
// Package: register indexes, frame header constants and the control bit
// bundle shared by the register block and its sub-modules.
// Assumes one register per 32-bit word; index 15 has no storage.
package vtx_regs_pkg;
    localparam int NREG       = 22;
    localparam int IDX_GCP    = 0;
    localparam int IDX_PAY0   = 1;
    localparam int PAY_BYTES  = 13;
    localparam int IDX_HIRATE = 14;
    localparam int IDX_STAT   = 16;
    localparam int IDX_HPACK  = 17;
    localparam int IDX_XRST   = 18;
    localparam int IDX_PRST   = 19;
    localparam int IDX_CFGEN  = 20;
    localparam int IDX_CFGCH  = 21;
    localparam int STAT_W     = 5;
    localparam int FRAME_W    = 8 * (PAY_BYTES + 1);

    localparam logic [7:0] HDR_TYPE = 8'h82;
    localparam logic [7:0] HDR_VER  = 8'h02;
    localparam logic [7:0] HDR_LEN  = 8'h0D;

    typedef struct packed {
        logic hi_rate;
        logic hp_ack;
        logic xcvr_rst;
        logic pll_rst;
        logic cfg_en;
    } vtx_ctl_t;
endpackage

// File: rtl/vtx_addr_dec.sv
// Address decoder: turns a byte address into a one-hot register select.
// Assumes NREG < 2**(ADDR_W-2); misaligned addresses select nothing.
module vtx_addr_dec #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 22
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // One comparator per register index.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = aligned && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/vtx_reg_bank.sv
// Register storage: control packet, payload bytes, control bits and the
// reconfiguration channel. Assumes wr_sel is one-hot or zero and already
// qualified with the write strobe. Synchronous active-low reset.
module vtx_reg_bank
    import vtx_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHAN_W = 8,
    localparam int PAY_W = 8 * PAY_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gcp,
    output logic [PAY_W-1:0]  payload,
    output vtx_ctl_t          ctl,
    output logic [CHAN_W-1:0] chan
);
    logic unused_wr;
    assign unused_wr = ^{wr_sel[IDX_HIRATE+1], wr_sel[IDX_STAT]};

    // Control packet word.
    always_ff @(posedge clk) begin
        if (!rst_n)                gcp <= '0;
        else if (wr_sel[IDX_GCP])  gcp <= wdata;
    end

    // One byte register per payload index.
    for (genvar g = 0; g < PAY_BYTES; g++) begin : g_pay
        always_ff @(posedge clk) begin
            if (!rst_n)                   payload[g*8 +: 8] <= 8'h00;
            else if (wr_sel[IDX_PAY0+g])  payload[g*8 +: 8] <= wdata[7:0];
        end
    end

    // Single-bit control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_sel[IDX_HIRATE]) ctl.hi_rate  <= wdata[0];
            if (wr_sel[IDX_HPACK])  ctl.hp_ack   <= wdata[0];
            if (wr_sel[IDX_XRST])   ctl.xcvr_rst <= wdata[0];
            if (wr_sel[IDX_PRST])   ctl.pll_rst  <= wdata[0];
            if (wr_sel[IDX_CFGEN])  ctl.cfg_en   <= wdata[0];
        end
    end

    // Reconfiguration channel number.
    always_ff @(posedge clk) begin
        if (!rst_n)                chan <= '0;
        else if (wr_sel[IDX_CFGCH]) chan <= wdata[CHAN_W-1:0];
    end
endmodule

// File: rtl/vtx_frame_sum.sv
// Frame checksum: two's complement of the 8-bit sum of the fixed header
// bytes and all payload bytes. Purely combinational, so it follows the
// payload registers with no added cycle.
module vtx_frame_sum
    import vtx_regs_pkg::*;
#(
    localparam int PAY_W = 8 * PAY_BYTES
) (
    input  logic [PAY_W-1:0] payload,
    output logic [7:0]       chk
);
    logic [7:0] acc;

    // Modulo-256 sum of header and payload.
    always_comb begin
        acc = HDR_TYPE + HDR_VER + HDR_LEN;
        for (int k = 0; k < PAY_BYTES; k++) begin
            acc = acc + payload[k*8 +: 8];
        end
    end

    assign chk = ~acc + 8'd1;
endmodule

// File: rtl/vtx_rd_mux.sv
// Read port: selects the addressed register and registers it for one
// cycle of latency. Assumes rd_sel is one-hot or zero. Output is zero
// after any cycle without a read strobe.
module vtx_rd_mux
    import vtx_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHAN_W = 8,
    localparam int PAY_W = 8 * PAY_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [NREG-1:0]   rd_sel,
    input  logic [DATA_W-1:0] gcp,
    input  logic [PAY_W-1:0]  payload,
    input  vtx_ctl_t          ctl,
    input  logic [CHAN_W-1:0] chan,
    input  logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] nxt;
    logic              unused_rd;

    assign unused_rd = rd_sel[IDX_HIRATE+1];

    // Select the addressed word, zero-extended.
    always_comb begin
        nxt = '0;
        if (rd_sel[IDX_GCP]) nxt = gcp;
        for (int k = 0; k < PAY_BYTES; k++) begin
            if (rd_sel[IDX_PAY0+k]) nxt[7:0] = payload[k*8 +: 8];
        end
        if (rd_sel[IDX_HIRATE]) nxt[0] = ctl.hi_rate;
        if (rd_sel[IDX_STAT])   nxt[STAT_W-1:0] = status;
        if (rd_sel[IDX_HPACK])  nxt[0] = ctl.hp_ack;
        if (rd_sel[IDX_XRST])   nxt[0] = ctl.xcvr_rst;
        if (rd_sel[IDX_PRST])   nxt[0] = ctl.pll_rst;
        if (rd_sel[IDX_CFGEN])  nxt[0] = ctl.cfg_en;
        if (rd_sel[IDX_CFGCH])  nxt[CHAN_W-1:0] = chan;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= nxt;
        else         rdata <= '0;
    end
endmodule

// File: rtl/vtx_ctrl_regs.sv
// Video transmitter control register block (top). Decodes the host bus,
// holds the control state, packs the frame with its checksum and returns
// registered read data. Assumes DATA_W >= 32 and CHAN_W <= DATA_W.
module vtx_ctrl_regs
    import vtx_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CHAN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                hotplug_evt,
    input  logic                cal_busy,
    input  logic                xcvr_cfg_busy,
    input  logic                pll_cfg_busy,
    input  logic                iopll_cfg_busy,
    output logic [DATA_W-1:0]   ctl_packet,
    output logic [FRAME_W-1:0]  info_frame,
    output logic                hi_rate_mode,
    output logic                hotplug_ack,
    output logic                xcvr_rst,
    output logic                pll_rst,
    output logic                reconf_en,
    output logic [CHAN_W-1:0]   reconf_chan
);
    localparam int PAY_W = 8 * PAY_BYTES;

    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   wr_sel;
    logic [PAY_W-1:0]  payload;
    logic [7:0]        chk;
    logic [STAT_W-1:0] status;
    vtx_ctl_t          ctl;

    assign wr_sel = sel & {NREG{bus_wr}};
    assign status = {iopll_cfg_busy, pll_cfg_busy, xcvr_cfg_busy, cal_busy, hotplug_evt};

    vtx_addr_dec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    vtx_reg_bank #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wdata   (bus_wdata),
        .gcp     (ctl_packet),
        .payload (payload),
        .ctl     (ctl),
        .chan    (reconf_chan)
    );

    vtx_frame_sum u_sum (
        .payload (payload),
        .chk     (chk)
    );

    vtx_rd_mux #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .rd_sel  (sel),
        .gcp     (ctl_packet),
        .payload (payload),
        .ctl     (ctl),
        .chan    (reconf_chan),
        .status  (status),
        .rdata   (bus_rdata)
    );

    assign info_frame   = {payload, chk};
    assign hi_rate_mode = ctl.hi_rate;
    assign hotplug_ack  = ctl.hp_ack;
    assign xcvr_rst     = ctl.xcvr_rst;
    assign pll_rst      = ctl.pll_rst;
    assign reconf_en    = ctl.cfg_en;
endmodule

// File: rtl/vtx_ctrl_regs_chk.sv
// Checker for vtx_ctrl_regs: port-level properties, attached by bind.
// Assumes the default register layout (index n at byte offset 4*n).
module vtx_ctrl_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CHAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              hotplug_evt,
    input logic              cal_busy,
    input logic              xcvr_cfg_busy,
    input logic              pll_cfg_busy,
    input logic              iopll_cfg_busy,
    input logic [DATA_W-1:0] ctl_packet,
    input logic [111:0]      info_frame,
    input logic              hi_rate_mode,
    input logic              hotplug_ack,
    input logic              xcvr_rst,
    input logic              pll_rst,
    input logic              reconf_en,
    input logic [CHAN_W-1:0] reconf_chan
);
    localparam logic [ADDR_W-1:0] A_GCP  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(64);
    localparam logic [ADDR_W-1:0] A_XRST = ADDR_W'(72);

    logic [7:0] tot;

    // Sum of every frame byte plus the header bytes.
    always_comb begin
        tot = 8'h82 + 8'h02 + 8'h0D;
        for (int k = 0; k < 14; k++) tot = tot + info_frame[k*8 +: 8];
    end

    AST_FRAME_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tot == 8'h00); // R4

    AST_GCP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_GCP) |=> ctl_packet == $past(bus_wdata)); // R2

    AST_XRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_XRST) |=> xcvr_rst == $past(bus_wdata[0])); // R8

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=>
        bus_rdata == DATA_W'($past({iopll_cfg_busy, pll_cfg_busy, xcvr_cfg_busy,
                                    cal_busy, hotplug_evt}))); // R7

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!xcvr_rst && !pll_rst && !hi_rate_mode && !hotplug_ack
                          && !reconf_en && reconf_chan == '0 && ctl_packet == '0
                          && info_frame == 112'h6F && bus_rdata == '0)); // R11
endmodule

bind vtx_ctrl_regs vtx_ctrl_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hotplug_evt(hotplug_evt), .cal_busy(cal_busy),
    .xcvr_cfg_busy(xcvr_cfg_busy), .pll_cfg_busy(pll_cfg_busy),
    .iopll_cfg_busy(iopll_cfg_busy), .ctl_packet(ctl_packet),
    .info_frame(info_frame), .hi_rate_mode(hi_rate_mode),
    .hotplug_ack(hotplug_ack), .xcvr_rst(xcvr_rst), .pll_rst(pll_rst),
    .reconf_en(reconf_en), .reconf_chan(reconf_chan)
);

// File: tb/sim_vtx_ctrl_regs.sv
// Bench for vtx_ctrl_regs: a write/readback vector table, then directed
// tests for reset, checksum timing, status, overlap and unmapped access.
module sim_vtx_ctrl_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         hotplug_evt = 1'b0, cal_busy = 1'b0, xcvr_cfg_busy = 1'b0;
    logic         pll_cfg_busy = 1'b0, iopll_cfg_busy = 1'b0;
    logic [31:0]  ctl_packet;
    logic [111:0] info_frame;
    logic         hi_rate_mode, hotplug_ack, xcvr_rst, pll_rst, reconf_en;
    logic [7:0]   reconf_chan;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;
    logic [7:0] pay [13];

    always #5 clk = ~clk;

    vtx_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hotplug_evt(hotplug_evt), .cal_busy(cal_busy),
        .xcvr_cfg_busy(xcvr_cfg_busy), .pll_cfg_busy(pll_cfg_busy),
        .iopll_cfg_busy(iopll_cfg_busy), .ctl_packet(ctl_packet),
        .info_frame(info_frame), .hi_rate_mode(hi_rate_mode),
        .hotplug_ack(hotplug_ack), .xcvr_rst(xcvr_rst), .pll_rst(pll_rst),
        .reconf_en(reconf_en), .reconf_chan(reconf_chan)
    );

    // {address, write data, expected readback}
    localparam int NV = 14;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 32'hDEADBEEF, 32'hDEADBEEF},
        {8'h04, 32'h12345678, 32'h00000078},
        {8'h08, 32'h000000FF, 32'h000000FF},
        {8'h30, 32'hA5A5A5C3, 32'h000000C3},
        {8'h34, 32'h00000011, 32'h00000011},
        {8'h38, 32'hFFFFFFFF, 32'h00000001},
        {8'h3C, 32'hFFFFFFFF, 32'h00000000},
        {8'h40, 32'h0000001F, 32'h00000000},
        {8'h44, 32'h00000003, 32'h00000001},
        {8'h48, 32'h00000001, 32'h00000001},
        {8'h4C, 32'h00000001, 32'h00000001},
        {8'h50, 32'hFFFFFFFE, 32'h00000000},
        {8'h54, 32'h12345607, 32'h00000007},
        {8'h58, 32'h0000FFFF, 32'h00000000}
    };

    function automatic string tag_of(input logic [7:0] a);
        if (a[1:0] != 2'b00 || a > 8'h54) return "R1";
        if (a == 8'h00) return "R2";
        if (a <= 8'h34) return "R3";
        if (a == 8'h38) return "R5";
        if (a == 8'h3C) return "R6";
        if (a == 8'h40) return "R7";
        if (a <= 8'h50) return "R8";
        return "R9";
    endfunction

    function automatic logic [111:0] model_frame();
        logic [111:0] f = '0;
        logic [7:0]   s = 8'h82 + 8'h02 + 8'h0D;
        for (int k = 0; k < 13; k++) begin
            f[8*(k+1) +: 8] = pay[k];
            s = s + pay[k];
        end
        f[7:0] = 8'h00 - s;
        return f;
    endfunction

    task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[1:0] == 2'b00 && a >= 8'h04 && a <= 8'h34) pay[a/4 - 1] = d[7:0];
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        for (int k = 0; k < 13; k++) pay[k] = 8'h00;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", {xcvr_rst, pll_rst, hi_rate_mode, hotplug_ack, reconf_en}, 0);
        check("R11", info_frame, 112'h6F);
        check("R11", bus_rdata, 0);
        rst_n = 1'b1;

        // Table: write then read back each vector
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][71:64], VEC[i][63:32]);
            do_read(VEC[i][71:64], rd);
            check(tag_of(VEC[i][71:64]), rd, VEC[i][31:0]);
        end

        // R3 R4: packed frame after table writes
        check("R3", info_frame[111:8], model_frame() >> 8);
        check("R4", info_frame[7:0], model_frame() & 112'hFF);
        check("R2", ctl_packet, 32'hDEADBEEF);
        check("R5", hi_rate_mode, 1);
        check("R8", {hotplug_ack, xcvr_rst, pll_rst, reconf_en}, 4'b1110);
        check("R9", reconf_chan, 8'h07);

        // R4: checksum follows a write on the next sampling point
        do_write(8'h14, 32'h0000005A);
        check("R4", info_frame, model_frame());
        for (int k = 0; k < 13; k++) do_write(8'(4*(k+1)), 32'hFF);
        check("R4", info_frame[7:0], 112'h7C);

        // R7: status inputs seen at the read cycle
        @(negedge clk); hotplug_evt = 1'b1; pll_cfg_busy = 1'b1;
        do_read(8'h40, rd);
        check("R7", rd, 32'h09);
        @(negedge clk); cal_busy = 1'b1; xcvr_cfg_busy = 1'b1; iopll_cfg_busy = 1'b1;
        do_read(8'h40, rd);
        check("R7", rd, 32'h1F);
        do_write(8'h40, 32'h0);
        do_read(8'h40, rd);
        check("R7", rd, 32'h1F);

        // R10: read and write in the same cycle return the old value
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'hCAFEF00D; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R10", bus_rdata, 32'hDEADBEEF);
        @(negedge clk);
        check("R10", bus_rdata, 0);
        do_read(8'h00, rd);
        check("R10", rd, 32'hCAFEF00D);

        // R1: misaligned access is unmapped
        do_write(8'h49, 32'h0);
        check("R1", xcvr_rst, 1);
        do_write(8'h01, 32'h0);
        check("R1", ctl_packet, 32'hCAFEF00D);
        do_read(8'h4A, rd);
        check("R1", rd, 0);

        // R11: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11", {ctl_packet, reconf_chan, xcvr_rst, pll_rst, hi_rate_mode}, 0);
        check("R11", info_frame, 112'h6F);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule